// File: doc/BRIEF.md
# Dual-Mode Transmit Serializer with Underflow Handling

This block turns bytes written by a host into one serial bit stream for a downstream modulator. Each bit period is marked by a single-cycle bit strobe from an external rate generator, so the same logic serves slow and fast line rates (for example 75, 150 or 1200 bit/s). The block has one holding register for the next byte and one shift register for the bit stream being sent. The host writes a byte whenever the data-ready flag is high.

There are two line formats. In synchronous mode each byte leaves as eight bare bits, least significant first, with no gap between bytes. In asynchronous mode each byte is framed as a character. The frame is a space start bit, then 7 or 8 data bits sent least significant first, then an optional even or odd parity bit, then one or two mark stop bits. If the host is late with the next byte, a sticky underflow flag is raised. An asynchronous line then idles at mark until a byte arrives. A synchronous line sends the byte still held in the register again. The line carries data only while transmit is enabled.

Top module: `dm_tx_serializer`

## Requirements
- R1: After reset `tx_line` is 1 (mark), `data_ready` is 1 and `underflow` is 0.
- R2: With `cfg_async`=0 a loaded byte is sent as exactly 8 bits, bit 0 first, one bit per strobe, with no start, parity or stop bits.
- R3: With `cfg_async`=1 a character is sent as a 0 start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits at 1. When `cfg_eight`=0, bit 7 of the written byte is not sent.
- R4: Format encodings are as follows. `cfg_eight`=1 selects 8 data bits and 0 selects 7. `cfg_par` 00 and 01 select no parity, 10 selects even and 11 selects odd. `cfg_two_stop`=1 selects two stop bits and 0 selects one. The format is taken when a byte is loaded into the shift register.
- R5: Parity covers only the data bits actually sent. With even parity the sent data bits plus the parity bit hold an even number of ones. With odd parity they hold an odd number.
- R6: While `tx_en` is 0 the line is at mark from the next clock, any character in progress is dropped, and strobes set no underflow.
- R7: A write to the data register drops `data_ready` on the next clock. `data_ready` returns to 1 on the clock of the strobe that moves the byte into the shift register. `tx_line` changes only on a clock where `bit_tick` is 1 or `tx_en` is 0.
- R8: If a byte is waiting when the last bit of a character has gone out, the next strobe sends that byte's first bit, with no idle bit between them.
- R9: A strobe that needs a new byte while none is waiting sets `underflow`. The flag stays set until a `flags_rd` pulse. A new underflow in the same clock as the read wins over the clear.
- R10: After an underflow in asynchronous mode the line sends mark on each strobe until a byte is written. The strobe after that write starts its character.
- R11: After an underflow in synchronous mode the byte still in the data register is sent again in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| tx_en | input | 1 | Transmit enable; 0 holds the line at mark |
| cfg_async | input | 1 | 1 = framed characters, 0 = bare bytes |
| cfg_eight | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_par | input | 2 | 0x none, 10 even, 11 odd parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte to transmit |
| flags_rd | input | 1 | Flags read strobe; clears underflow |
| tx_line | output | 1 | Serial output to the modulator |
| data_ready | output | 1 | Data register can take a byte |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The hardest situation to reach is the seam between two characters. Here the strobe that would carry the next start bit either finds a byte already waiting or finds none. The stimulus controls every strobe by hand. It writes the second byte in the middle of the first character to produce a seamless join. It withholds a byte past the last stop bit to force an underflow. In synchronous mode it repeats the withholding so that the held byte is sent a second time.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic       async;
    logic       eight;
    logic [1:0] par;
    logic       two;
  } cfg_t;

  typedef struct packed {
    logic [CNT_W-1:0]   len;
    logic [FRAME_W-1:0] bits;
  } frame_t;

  function automatic logic char_parity(input logic [DATA_W-1:0] d,
                                       input logic eight, input logic odd);
    logic [DATA_W-1:0] m;
    m = d;
    if (!eight) m[DATA_W-1] = 1'b0;
    return (^m) ^ odd;
  endfunction

  function automatic frame_t build_frame(input logic [DATA_W-1:0] d, input cfg_t c);
    frame_t f;
    int nd;
    int pos;
    f.bits = '1;
    if (!c.async) begin
      f.bits[DATA_W-1:0] = d;
      f.len = CNT_W'(DATA_W);
    end else begin
      nd = c.eight ? DATA_W : DATA_W - 1;
      f.bits[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++)
        if (i < nd) f.bits[1+i] = d[i];
      pos = 1 + nd;
      if (c.par[1]) begin
        f.bits[pos] = char_parity(d, c.eight, c.par[0]);
        pos = pos + 1;
      end
      f.len = CNT_W'(pos + (c.two ? 2 : 1));
    end
    return f;
  endfunction
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg
  import tx_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  input  logic              uflow_evt,
  input  logic              flags_rd,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full,
  output logic              uflow_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data  <= '0;
      hold_full  <= 1'b0;
      uflow_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        hold_data <= wr_data;
        hold_full <= 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end
      if (uflow_evt)     uflow_flag <= 1'b1;
      else if (flags_rd) uflow_flag <= 1'b0;
    end
  end

  // R7
  wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> hold_full);
  // R7
  take_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !wr_en |=> !hold_full);
  // R9
  uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_evt |=> uflow_flag);
  // R9
  uf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_rd && !uflow_evt |=> !uflow_flag);
endmodule

// File: rtl/tx_shift_engine.sv
module tx_shift_engine
  import tx_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  cfg_t              cfg,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              tx_line,
  output logic              take,
  output logic              uflow_evt
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  frame_t             nf;
  logic               need;

  assign nf        = build_frame(hold_data, cfg);
  assign need      = tx_en && bit_tick && (cnt_q == '0);
  assign take      = need && hold_full;
  assign uflow_evt = need && !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      tx_line <= 1'b1;
      sh_q    <= '1;
      cnt_q   <= '0;
    end else if (bit_tick) begin
      if (cnt_q == '0) begin
        if (hold_full || !cfg.async) begin
          tx_line <= nf.bits[0];
          sh_q    <= {1'b1, nf.bits[FRAME_W-1:1]};
          cnt_q   <= nf.len - CNT_W'(1);
        end else begin
          tx_line <= 1'b1;
        end
      end else begin
        tx_line <= sh_q[0];
        sh_q    <= {1'b1, sh_q[FRAME_W-1:1]};
        cnt_q   <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R6
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tx_line);
  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && !bit_tick |=> $stable(tx_line));
  // R3
  start_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && cfg.async |=> !tx_line);
  // R10
  uf_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_evt && cfg.async |=> tx_line);
endmodule

// File: rtl/dm_tx_serializer.sv
module dm_tx_serializer
  import tx_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       tx_en,
  input  logic       cfg_async,
  input  logic       cfg_eight,
  input  logic [1:0] cfg_par,
  input  logic       cfg_two_stop,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       flags_rd,
  output logic       tx_line,
  output logic       data_ready,
  output logic       underflow
);
  cfg_t              cfg;
  logic              take;
  logic              uflow_evt;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;

  assign cfg        = '{async: cfg_async, eight: cfg_eight, par: cfg_par, two: cfg_two_stop};
  assign data_ready = !hold_full;

  tx_hold_reg u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .uflow_evt(uflow_evt), .flags_rd(flags_rd),
    .hold_data(hold_data), .hold_full(hold_full), .uflow_flag(underflow)
  );

  tx_shift_engine u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .cfg(cfg),
    .hold_full(hold_full), .hold_data(hold_data),
    .tx_line(tx_line), .take(take), .uflow_evt(uflow_evt)
  );

  // R11
  sync_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_evt && !cfg_async |=> tx_line == $past(hold_data[0]));
endmodule

// File: tb/dm_tx_serializer_bench.sv
`timescale 1ns/1ps
module dm_tx_serializer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, tx_en = 1'b0, cfg_async = 1'b0, cfg_eight = 1'b1;
  logic [1:0] cfg_par = 2'b00;
  logic cfg_two_stop = 1'b0, wr_en = 1'b0, flags_rd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic tx_line, data_ready, underflow;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dm_tx_serializer u_dm_tx_serializer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .cfg_async(cfg_async), .cfg_eight(cfg_eight), .cfg_par(cfg_par),
    .cfg_two_stop(cfg_two_stop), .wr_en(wr_en), .wr_data(wr_data),
    .flags_rd(flags_rd), .tx_line(tx_line), .data_ready(data_ready),
    .underflow(underflow)
  );

  // {async, eight, par[1:0], two, data[7:0], len[3:0], bits-in-send-order[11:0]}
  localparam logic [28:0] VEC [7] = '{
    {1'b0, 1'b1, 2'b00, 1'b0, 8'hA5, 4'd8,  12'h0A5},
    {1'b1, 1'b1, 2'b00, 1'b0, 8'h3C, 4'd10, 12'h278},
    {1'b1, 1'b0, 2'b10, 1'b0, 8'h41, 4'd10, 12'h282},
    {1'b1, 1'b1, 2'b11, 1'b1, 8'hFF, 4'd12, 12'hFFE},
    {1'b1, 1'b0, 2'b01, 1'b1, 8'h80, 4'd10, 12'h300},
    {1'b1, 1'b1, 2'b10, 1'b0, 8'h01, 4'd11, 12'h602},
    {1'b1, 1'b0, 2'b11, 1'b0, 8'h7F, 4'd10, 12'h2FE}
  };

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got 1 expected 0");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 line", tx_line, 1);
    check("R1 ready", data_ready, 1);
    check("R1 underflow", underflow, 0);

    foreach (VEC[v]) begin
      @(negedge clk) begin
        tx_en = 1'b0;
        {cfg_async, cfg_eight, cfg_par, cfg_two_stop} = VEC[v][28:24];
      end
      write(VEC[v][23:16]);
      check("R7 ready low", data_ready, 0);
      @(negedge clk) tx_en = 1'b1;
      check("R7 no strobe", tx_line, 1);
      for (int b = 0; b < int'(VEC[v][15:12]); b++) begin
        tick();
        check(VEC[v][28] ? "R3 R4 R5 bit" : "R2 bit", tx_line, VEC[v][b]);
        if (b == 0) check("R7 ready high", data_ready, 1);
      end
      @(negedge clk) tx_en = 1'b0;
      @(negedge clk);
      check("R6 mark", tx_line, 1);
      check("R9 no underflow", underflow, 0);
    end

    // back-to-back async 8N1, then async underflow
    @(negedge clk) begin
      cfg_async = 1'b1; cfg_eight = 1'b1; cfg_par = 2'b00; cfg_two_stop = 1'b0;
    end
    write(8'h55);
    @(negedge clk) tx_en = 1'b1;
    tick();
    check("R8 first start", tx_line, 0);
    write(8'hAA);
    check("R7 ready low mid", data_ready, 0);
    for (int b = 1; b < 10; b++) tick();
    check("R8 last stop", tx_line, 1);
    tick();
    check("R8 seamless start", tx_line, 0);
    check("R8 ready", data_ready, 1);
    check("R8 no underflow", underflow, 0);
    tick();
    check("R8 data bit0", tx_line, 0);
    tick();
    check("R8 data bit1", tx_line, 1);
    for (int b = 3; b < 10; b++) tick();
    tick();
    check("R10 mark", tx_line, 1);
    check("R9 set", underflow, 1);
    tick();
    tick();
    check("R10 still mark", tx_line, 1);
    check("R9 sticky", underflow, 1);
    write(8'h00);
    check("R10 waits for strobe", tx_line, 1);
    tick();
    check("R10 resume start", tx_line, 0);
    @(negedge clk) flags_rd = 1'b1;
    @(negedge clk) flags_rd = 1'b0;
    check("R9 cleared", underflow, 0);

    // sync underflow repeat
    @(negedge clk) begin tx_en = 1'b0; cfg_async = 1'b0; end
    write(8'h5A);
    @(negedge clk) tx_en = 1'b1;
    for (int b = 0; b < 8; b++) begin
      tick();
      check("R2 sync bit", tx_line, 12'((8'h5A >> b) & 1));
    end
    check("R9 none yet", underflow, 0);
    for (int b = 0; b < 8; b++) begin
      tick();
      check("R11 repeat bit", tx_line, 12'((8'h5A >> b) & 1));
      if (b == 0) check("R11 underflow", underflow, 1);
    end

    // disable mid-character
    @(negedge clk) begin flags_rd = 1'b1; cfg_async = 1'b1; end
    @(negedge clk) flags_rd = 1'b0;
    write(8'h00);
    tick();
    check("R6 running", tx_line, 0);
    @(negedge clk) tx_en = 1'b0;
    @(negedge clk);
    check("R6 drop", tx_line, 1);
    tick();
    tick();
    check("R6 idle line", tx_line, 1);
    check("R6 no underflow", underflow, 0);

    done = 1'b1;
    summary();
  end
endmodule